// File: doc/BRIEF.md
# Allocation Tag Block Transfer Unit

This unit moves groups of 4-bit allocation tags between a 64-bit register word and a byte-wide tag memory. Each tag guards one 16-byte data granule, and a tag byte holds two of them. The even granule sits in bits 3:0 and the odd granule in bits 7:4. A request names an operation, a physical address and a size field. The unit aligns the address down to the block, works out the first tag byte as the aligned address divided by 32, and then moves one tag byte per cycle through a synchronous SRAM port with one cycle of read latency.

There are three operations. A bulk read gathers the tag bytes of a block into the 64-bit word. The register word is indexed by address bits 7:4, so a block smaller than 256 bytes lands shifted inside the word. A bulk write is the reverse: it takes the matching slice of the word and stores it. A block fill writes one replicated tag pair into every tag byte of a larger zeroing block. An untagged-page flag sent with the request cancels the memory traffic. An illegal size or operation code returns an error and does not touch memory.

Top module: `tag_xfer_unit`

## Requirements
- R1: A read or write whose size code `req_bs` lies outside 3..6, or a request with the reserved operation code 3, finishes with `err`=1 and `rd_data`=0, and makes no memory access.
- R2: A read or write with size code B covers a block of 4<<B bytes. The address is aligned down to that size. The unit accesses the 1<<(B-3) tag bytes that start at the aligned address >> 5, in ascending order, at consecutive addresses.
- R3: A bulk read returns tag byte k at bits [S+8k+7 : S+8k] of `rd_data`, where S = 4 * (aligned address bits 7:4). All other bits are 0.
- R4: A bulk write stores byte k of (`req_wdata` >> S) into tag byte (aligned address >> 5) + k, with S defined as in R3. No other byte changes.
- R5: With `req_untagged`=1, a read returns 0, and no operation accesses memory or changes any tag byte.
- R6: A fill (operation 2) with zero-size code Z in 4..9 aligns the address down to 2^(Z+2) bytes. It writes {`req_wdata`[3:0], `req_wdata`[3:0]} into each of the 2^(Z-3) tag bytes of that block. A Z outside 4..9 gives `err`=1 and no access.
- R7: The unit accepts a request when `req_valid`=1 and `busy`=0. `busy` stays high until the request completes. `done` then pulses for exactly one cycle with `busy`=0, and `rd_data` and `err` are valid in that cycle. Operation codes: 0 read, 1 write, 2 fill.
- R8: After reset, `busy`, `done`, `err` and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 fill, 3 reserved |
| req_addr | input | ADDR_W | Physical byte address |
| req_bs | input | 3 | Block size code for read/write (valid 3..6) |
| req_zsz | input | 4 | Zeroing block size code for fill (valid 4..9) |
| req_wdata | input | 64 | Tag word for write; bits 3:0 are the fill tag |
| req_untagged | input | 1 | Page holds no tags; suppress the access |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completed request was illegal |
| rd_data | output | 64 | Bulk read result |
| mem_en | output | 1 | Tag memory enable |
| mem_we | output | 1 | Tag memory write enable |
| mem_addr | output | ADDR_W-5 | Tag memory byte address |
| mem_wdata | output | 8 | Tag memory write byte |
| mem_rdata | input | 8 | Tag memory read byte, one cycle after enable |

## Verification
Partial-block reads and writes at a nonzero granule offset are hard to reach. Only addresses whose bits 7:4 are nonzero after alignment move the tag bytes inside the 64-bit word, and the offset depends on the size code and the address together. The stimulus fixes directed addresses for each size code at the top of a 256-byte window. It then draws random 15-bit addresses with random size codes, so every shift value shows up. An untagged read is issued over memory that holds nonzero tags, so a zero result cannot come from empty memory. The largest fill spans the full 64-byte tag range of its block.

// File: rtl/tag_xfer_pkg.sv
package tag_xfer_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FILL  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } st_e;

  localparam int unsigned WORD_W  = 64;
  localparam int unsigned WORD_NB = WORD_W / 8;
  localparam int unsigned TAGB_LG = 5;  // 32 data bytes per tag byte
endpackage

// File: rtl/tag_addr_calc.sv
module tag_addr_calc
  import tag_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned ZMIN   = 4,
  parameter int unsigned ZMAX   = 9,
  localparam int unsigned MEM_AW = ADDR_W - TAGB_LG
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        bs,
  input  logic [3:0]        zsz,
  output logic [MEM_AW-1:0] base,
  output logic [CNT_W-1:0]  nbytes,
  output logic [5:0]        shift,
  output logic              bad
);
  logic [4:0]        lg;
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    bad = 1'b0;
    lg  = 5'(TAGB_LG);
    unique case (op_e'(op))
      OP_READ, OP_WRITE: begin
        if (bs >= 3'd3 && bs <= 3'd6) lg = 5'(bs) + 5'd2;
        else bad = 1'b1;
      end
      OP_FILL: begin
        if (32'(zsz) >= ZMIN && 32'(zsz) <= ZMAX) lg = 5'(zsz) + 5'd2;
        else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    aligned = addr & ~((ADDR_W'(1) << lg) - ADDR_W'(1));
    base    = aligned[ADDR_W-1:TAGB_LG];
    nbytes  = CNT_W'(1) << (lg - 5'(TAGB_LG));
    shift   = {aligned[7:4], 2'b00};
  end
endmodule

// File: rtl/tag_wbyte_sel.sv
module tag_wbyte_sel
  import tag_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] wdata,
  input  logic [5:0]        shift,
  input  logic [CNT_W-1:0]  idx,
  output logic [7:0]        wbyte
);
  logic [WORD_W-1:0] slid;
  logic [7:0]        lanes [WORD_NB];

  assign slid = wdata >> shift;

  for (genvar g = 0; g < WORD_NB; g++) begin : g_lane
    assign lanes[g] = slid[8*g +: 8];
  end

  always_comb begin
    if (op_e'(op) == OP_FILL) wbyte = {wdata[3:0], wdata[3:0]};
    else                      wbyte = lanes[idx[2:0]];
  end
endmodule

// File: rtl/tag_rd_assemble.sv
module tag_rd_assemble
  import tag_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic [2:0]        cap_idx,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] acc
);
  for (genvar g = 0; g < WORD_NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst || clr)                  acc[8*g +: 8] <= 8'h00;
      else if (cap && cap_idx == 3'(g)) acc[8*g +: 8] <= din;
    end
  end
endmodule

// File: rtl/tag_xfer_unit.sv
module tag_xfer_unit
  import tag_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ZMIN   = 4,
  parameter int unsigned ZMAX   = 9,
  localparam int unsigned MEM_AW = ADDR_W - TAGB_LG,
  localparam int unsigned CNT_W  = $clog2((1 << (ZMAX - 3)) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_bs,
  input  logic [3:0]        req_zsz,
  input  logic [63:0]       req_wdata,
  input  logic              req_untagged,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [63:0]       rd_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  st_e               state;
  logic [1:0]        op_q;
  logic [MEM_AW-1:0] base_q;
  logic [CNT_W-1:0]  nb_q;
  logic [CNT_W-1:0]  idx;
  logic [5:0]        shift_q;
  logic [63:0]       wdata_q;
  logic              skip_q;
  logic              bad_q;
  logic              rd_pend;
  logic [2:0]        rd_idx;

  logic [MEM_AW-1:0] c_base;
  logic [CNT_W-1:0]  c_nb;
  logic [5:0]        c_shift;
  logic              c_bad;
  logic              accept;
  logic [63:0]       acc;

  assign accept = req_valid && (state == ST_IDLE);

  tag_addr_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ZMIN(ZMIN), .ZMAX(ZMAX)
  ) u_calc (
    .op(req_op), .addr(req_addr), .bs(req_bs), .zsz(req_zsz),
    .base(c_base), .nbytes(c_nb), .shift(c_shift), .bad(c_bad)
  );

  tag_wbyte_sel #(.CNT_W(CNT_W)) u_wsel (
    .op(op_q), .wdata(wdata_q), .shift(shift_q), .idx(idx), .wbyte(mem_wdata)
  );

  tag_rd_assemble u_asm (
    .clk(clk), .rst(rst), .clr(accept), .cap(rd_pend),
    .cap_idx(rd_idx), .din(mem_rdata), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= 2'd0;
      base_q  <= '0;
      nb_q    <= '0;
      idx     <= '0;
      shift_q <= '0;
      wdata_q <= '0;
      skip_q  <= 1'b0;
      bad_q   <= 1'b0;
      rd_pend <= 1'b0;
      rd_idx  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      rd_pend <= (state == ST_RUN) && (op_e'(op_q) == OP_READ);
      rd_idx  <= idx[2:0];
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= req_op;
            base_q  <= c_base;
            nb_q    <= c_nb;
            shift_q <= c_shift;
            wdata_q <= req_wdata;
            skip_q  <= req_untagged;
            bad_q   <= c_bad;
            idx     <= '0;
            state   <= (c_bad || req_untagged) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          idx <= idx + CNT_W'(1);
          if (idx == nb_q - CNT_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_FIN;
        ST_FIN: begin
          done    <= 1'b1;
          err     <= bad_q;
          rd_data <= (op_e'(op_q) == OP_READ && !skip_q && !bad_q) ? (acc << shift_q) : 64'd0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign mem_en   = (state == ST_RUN);
  assign mem_we   = (state == ST_RUN) && (op_e'(op_q) != OP_READ);
  assign mem_addr = base_q + MEM_AW'(idx);
endmodule

// File: rtl/tag_xfer_chk.sv
module tag_xfer_chk #(
  parameter int unsigned MEM_AW = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_untagged,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r1_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r5_untagged_noacc: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_untagged) |=> !mem_en);

  a_r2_consecutive: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1)));

  a_r4_we_in_access: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);
endmodule

bind tag_xfer_unit tag_xfer_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_untagged(req_untagged),
  .busy(busy), .done(done), .err(err), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/tb_tag_xfer_unit.sv
module tb_tag_xfer_unit;
  localparam int ADDR_W = 32;
  localparam int MEM_AW = ADDR_W - 5;
  localparam int DEPTH  = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_bs = 3'd3;
  logic [3:0]        req_zsz = 4'd4;
  logic [63:0]       req_wdata = '0;
  logic              req_untagged = 1'b0;
  logic              busy, done, err, mem_en, mem_we;
  logic [63:0]       rd_data;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;

  logic [7:0] sram   [DEPTH];
  logic [7:0] shadow [DEPTH];
  int n_checks = 0;
  int n_errors = 0;
  int acc_cnt  = 0;

  always #5 clk = ~clk;

  tag_xfer_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_bs(req_bs), .req_zsz(req_zsz),
    .req_wdata(req_wdata), .req_untagged(req_untagged), .busy(busy),
    .done(done), .err(err), .rd_data(rd_data), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) sram[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= sram[mem_addr[9:0]];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lg_of(input int op, input int bs, input int z);
    if (op == 0 || op == 1) return (bs >= 3 && bs <= 6) ? bs + 2 : -1;
    if (op == 2) return (z >= 4 && z <= 9) ? z + 2 : -1;
    return -1;
  endfunction

  task automatic run_op(input int op, input int addr, input int bs, input int z,
                        input logic [63:0] wd, input bit untag, input string req);
    int lg, base, tb, nb, sh, exp_cnt, mism;
    logic [63:0] exp_rd;
    bit exp_err, got;
    lg = lg_of(op, bs, z);
    exp_err = (lg < 0);
    exp_rd = 64'd0;
    exp_cnt = 0;
    if (!exp_err && !untag) begin
      base = addr & ~((1 << lg) - 1);
      tb = base >> 5;
      nb = 1 << (lg - 5);
      sh = ((base >> 4) & 15) * 4;
      exp_cnt = nb;
      for (int k = 0; k < nb; k++) begin
        if (op == 0) exp_rd |= 64'(shadow[tb + k]) << (sh + 8 * k);
        else if (op == 1) shadow[tb + k] = 8'((wd >> sh) >> (8 * k));
        else shadow[tb + k] = {wd[3:0], wd[3:0]};
      end
    end
    @(negedge clk);
    acc_cnt = 0;
    req_valid = 1'b1; req_op = 2'(op); req_addr = ADDR_W'(addr);
    req_bs = 3'(bs); req_zsz = 4'(z); req_wdata = wd; req_untagged = untag;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int t = 0; t < 200 && !got; t++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    check(got, {req, " R7 done timeout"}, 64'(got), 64'd1);
    if (!got) return;
    check(!busy, {req, " R7 busy low at done"}, 64'(busy), 64'd0);
    check(err == exp_err, {req, " R1/R6 err"}, 64'(err), 64'(exp_err));
    if (op == 0 || exp_err)
      check(rd_data == exp_rd, {req, " R3 rd_data"}, rd_data, exp_rd);
    check(acc_cnt == exp_cnt, {req, " R2 access count"}, 64'(acc_cnt), 64'(exp_cnt));
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (sram[i] !== shadow[i]) mism++;
    check(mism == 0, {req, " R4 memory image"}, 64'(mism), 64'd0);
    @(negedge clk);
    check(!done, {req, " R7 done single pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < DEPTH; i++) begin
      sram[i] = 8'($urandom);
      shadow[i] = sram[i];
    end
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!busy && !done && !err && !mem_en, "R8 reset outputs",
          {60'd0, busy, done, err, mem_en}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // R1: illegal sizes and op code
    run_op(0, 32'h100, 2, 4, 64'd0, 0, "R1 read bs2");
    run_op(1, 32'h100, 7, 4, 64'hFFFF, 0, "R1 write bs7");
    run_op(3, 32'h100, 4, 4, 64'd0, 0, "R1 rsvd op");
    // R6: illegal fill sizes
    run_op(2, 32'h200, 3, 3, 64'h5, 0, "R6 fill z3");
    run_op(2, 32'h200, 3, 10, 64'h5, 0, "R6 fill z10");
    // R2/R3: reads at top of window for each size
    for (int b = 3; b <= 6; b++) begin
      run_op(0, 32'h1F0 + 32'h1000 * b, b, 4, 64'd0, 0, "R3 read shifted");
      run_op(0, 32'h400 + 32'h13, b, 4, 64'd0, 0, "R2 read aligned");
    end
    // R4: writes at offset, then read back
    run_op(1, 32'h2E0, 3, 4, 64'h0123_4567_89AB_CDEF, 0, "R4 write bs3");
    run_op(1, 32'h2C8, 4, 4, 64'hFEDC_BA98_7654_3210, 0, "R4 write bs4");
    run_op(1, 32'h580, 5, 4, 64'hA5A5_5A5A_C3C3_3C3C, 0, "R4 write bs5");
    run_op(0, 32'h2C0, 6, 4, 64'd0, 0, "R3 readback bs6");
    // R5: untagged accesses
    run_op(0, 32'h300, 6, 4, 64'd0, 1, "R5 untagged read");
    run_op(1, 32'h300, 6, 4, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R5 untagged write");
    run_op(2, 32'h300, 6, 9, 64'h7, 1, "R5 untagged fill");
    // R6: fills at both size limits
    run_op(2, 32'h3FF0, 3, 4, 64'hB, 0, "R6 fill z4");
    run_op(2, 32'h5123, 3, 9, 64'hFFF6, 0, "R6 fill z9");
    run_op(0, 32'h5000, 6, 4, 64'd0, 0, "R6 fill readback");
    // random mix
    for (int n = 0; n < 300; n++) begin
      run_op(int'($urandom_range(0, 3)), int'($urandom_range(0, 32767)),
             int'($urandom_range(2, 7)), int'($urandom_range(3, 10)),
             {$urandom, $urandom}, ($urandom_range(0, 7) == 0), "R2 random");
    end
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL R7 watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule